// File: doc/BRIEF.md
# Multi-format serial audio transmitter (bus master)

This block sends audio samples out on a three-wire serial audio link and drives that link as its master. It generates the bit clock and the word-select line itself. It takes 32-bit samples from a show-ahead FIFO, one sample at the start of each channel slot, and shifts the selected word out MSB first. Four framings are available: left-justified, I2S, and two TDM variants. A TDM frame carries from one to eight slots.

The input clock is divided by a programmable factor. The divided ticks drive an eight-step phase counter, so one bit period lasts eight divided ticks. The bit clock is low during the first four phases and high during the last four. Serial data and word-select change only at the start of a bit period. Each slot has a channel length, and within it a shorter word length. The remaining positions of the slot carry a programmable fill bit.

A pause input replaces the sample bits with zeros and leaves the FIFO untouched. An empty FIFO at a slot start also produces zero sample bits and a one-cycle underflow pulse. The configuration is expected to change only while the enable is low. Pause is the exception and may change at any time; it takes effect at the next slot start.

Top module: `tdm_tx_master`

## Requirements
- R1: While `txEn` is low and from reset onward, `ws` and `sdo` are 0, `sck` equals `cfgSckPol`, and neither `fifoPop` nor `underflow` is asserted.
- R2: With divider code d, every bit period lasts 8*(d+1) clock cycles. With `cfgSckPol`=0, `sck` is low for the first half of the period and high for the second half, so data changes on the falling edge. With `cfgSckPol`=1, `sck` is inverted and `ws`/`sdo` are unchanged.
- R3: Length codes 0,1,2,3,4,5 select 8,16,18,20,24,32 bits, and codes 6 and 7 select 32. A frame has `cfgChCount`+1 slots of the channel length each.
- R4: A slot carries bits [W-1:0] of its sample, MSB first, where W is the word length. The slot positions from W up to the channel length carry `cfgOvh`.
- R5: Left-justified (`cfgMode`=0): `ws` is 1 during slot 0 and 0 otherwise, and the MSB of slot 0 is sent in the first bit period of the frame.
- R6: I2S (`cfgMode`=1): `ws` is 0 during slot 0 and 1 otherwise. Serial data lags the slot grid by one bit period, so `ws` changes one bit before each MSB.
- R7: TDM A (`cfgMode`=2): data is aligned to the frame start. `ws` is 1 only for the first bit of slot 0 when `cfgWsWide`=0, and for the whole of slot 0 when `cfgWsWide`=1.
- R8: TDM B (`cfgMode`=3): `ws` behaves as in TDM A, and the data lags by one bit period, so the first slot's MSB follows the `ws` rising edge by one bit clock.
- R9: At each slot start (when not paused and the FIFO is not empty), `fifoPop` is high for exactly one cycle, and the sample on `fifoData` in that cycle is the one sent. No pop happens anywhere else.
- R10: While `cfgPause` is 1, the sample bits are sent as 0, the fill positions still carry `cfgOvh`, and neither `fifoPop` nor `underflow` is asserted.
- R11: When the FIFO is empty at a slot start, the slot's sample bits are 0, `underflow` pulses for one cycle, and no pop happens.
- R12: The first bit period of slot 0 begins on the clock edge after `txEn` rises. Lowering `txEn` returns the outputs to the R1 idle state on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txEn | input | 1 | Run enable; a rising edge starts a frame |
| cfgMode | input | 2 | 0 left-justified, 1 I2S, 2 TDM A, 3 TDM B |
| cfgChCount | input | 3 | Slots per frame minus one |
| cfgChLen | input | 3 | Channel length code |
| cfgWordLen | input | 3 | Word length code |
| cfgWsWide | input | 1 | TDM word-select width: 0 one bit, 1 one slot |
| cfgOvh | input | 1 | Fill bit for positions beyond the word |
| cfgPause | input | 1 | Send zero sample bits without popping |
| cfgSckPol | input | 1 | Invert the outgoing bit clock |
| cfgDiv | input | 6 | Clock divider code d (divide by d+1) |
| fifoData | input | 32 | Head sample of the show-ahead FIFO |
| fifoEmpty | input | 1 | FIFO holds no sample |
| fifoPop | output | 1 | Removes the head sample |
| underflow | output | 1 | One-cycle pulse: slot started with the FIFO empty |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select / frame sync |
| sdo | output | 1 | Serial data |

## Verification
The bench builds the block with its default parameters: 32-bit samples, up to eight slots and a 6-bit divider code. With these values every length code and every slot count can be driven directly. It sweeps every channel-length and word-length pair in both two-slot framings, and every TDM variant with both word-select widths over one, four and eight slots. For each of these runs it predicts every bit period of `sck`, `ws` and `sdo` arithmetically, and counts pops and underflows. Separate runs cover a non-zero divider, the inverted bit clock, pause and a FIFO that runs dry partway through.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  localparam int LEN_W = 6;

  typedef enum logic [1:0] {
    FMT_LJ    = 2'd0,
    FMT_I2S   = 2'd1,
    FMT_TDM_A = 2'd2,
    FMT_TDM_B = 2'd3
  } txFormat_t;

  // strobes from control to datapath
  typedef struct packed {
    logic idle;       // no frame running
    logic load;       // a slot starts: take a new sample
    logic bitAdv;     // end of a bit period
    logic inWord;     // current slot position lies inside the word
    logic delayMode;  // data lags the slot grid by one bit
  } txStrobe_t;

  function automatic logic [LEN_W-1:0] decodeLen(input logic [2:0] code);
    case (code)
      3'd0:    decodeLen = 6'd8;
      3'd1:    decodeLen = 6'd16;
      3'd2:    decodeLen = 6'd18;
      3'd3:    decodeLen = 6'd20;
      3'd4:    decodeLen = 6'd24;
      default: decodeLen = 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/tdm_tx_ctrl.sv
module tdm_tx_ctrl
  import tdm_tx_pkg::*;
#(
  parameter int MAX_CH   = 8,
  parameter int DIV_W    = 6,
  parameter int PHASES   = 8,
  parameter int SAMPLE_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      txEn,
  input  txFormat_t                 fmt,
  input  logic [$clog2(MAX_CH)-1:0] chCount,
  input  logic [LEN_W-1:0]          chLen,
  input  logic [LEN_W-1:0]          wordLen,
  input  logic                      wsWide,
  input  logic                      sckPol,
  input  logic [DIV_W-1:0]          divCode,
  output txStrobe_t                 strobe,
  output logic                      sck,
  output logic                      ws
);

  localparam int SLOT_W = $clog2(MAX_CH);
  localparam int PH_W   = $clog2(PHASES);
  localparam int POS_W  = $clog2(SAMPLE_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(PHASES / 2);

  logic              running;
  logic [DIV_W-1:0]  divCnt;
  logic [PH_W-1:0]   phase;
  logic [POS_W-1:0]  pos;
  logic [SLOT_W-1:0] slot;

  logic tick, bitAdv, lastPos, lastSlot, load, wsRaw;

  assign tick     = running && (divCnt == divCode);
  assign bitAdv   = txEn && tick && (phase == PH_LAST);
  assign lastPos  = ({1'b0, pos} == (chLen - 6'd1));
  assign lastSlot = (slot == chCount);
  assign load     = txEn && (!running || (bitAdv && lastPos));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      divCnt  <= '0;
      phase   <= '0;
      pos     <= '0;
      slot    <= '0;
    end else if (!txEn) begin
      running <= 1'b0;
      divCnt  <= '0;
      phase   <= '0;
      pos     <= '0;
      slot    <= '0;
    end else if (!running) begin
      running <= 1'b1;
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) begin
        phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
      end
      if (bitAdv) begin
        if (lastPos) begin
          pos  <= '0;
          slot <= lastSlot ? '0 : slot + 1'b1;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

  // word select on the undelayed slot grid
  always_comb begin
    case (fmt)
      FMT_LJ:  wsRaw = (slot == '0);
      FMT_I2S: wsRaw = (slot != '0);
      default: wsRaw = (slot == '0) && (wsWide || (pos == '0));
    endcase
  end

  assign ws  = running && wsRaw;
  assign sck = running ? ((phase >= PH_HALF) ^ sckPol) : sckPol;

  always_comb begin
    strobe.idle      = !running;
    strobe.load      = load;
    strobe.bitAdv    = bitAdv;
    strobe.inWord    = ({1'b0, pos} < wordLen);
    strobe.delayMode = (fmt == FMT_I2S) || (fmt == FMT_TDM_B);
  end

endmodule

// File: rtl/tdm_tx_datapath.sv
module tdm_tx_datapath
  import tdm_tx_pkg::*;
#(
  parameter int SAMPLE_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobe_t           strobe,
  input  logic [LEN_W-1:0]    wordLen,
  input  logic                ovhBit,
  input  logic                pause,
  input  logic [SAMPLE_W-1:0] fifoData,
  input  logic                fifoEmpty,
  output logic                fifoPop,
  output logic                underflow,
  output logic                sdo
);

  logic [SAMPLE_W-1:0] shiftReg;
  logic [LEN_W-1:0]    shAmt;
  logic                delayBit;
  logic                curBit;
  logic                takeSample;

  assign shAmt      = LEN_W'(SAMPLE_W) - wordLen;
  assign takeSample = strobe.load && !pause;
  assign fifoPop    = takeSample && !fifoEmpty;
  assign underflow  = takeSample && fifoEmpty;
  assign curBit     = strobe.inWord ? shiftReg[SAMPLE_W-1] : ovhBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.load) begin
      // word MSB moved to the top bit; pause or empty loads zeros
      shiftReg <= fifoPop ? (fifoData << shAmt) : '0;
    end else if (strobe.idle) begin
      shiftReg <= '0;
    end else if (strobe.bitAdv) begin
      shiftReg <= shiftReg << 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayBit <= 1'b0;
    end else if (strobe.idle) begin
      delayBit <= 1'b0;
    end else if (strobe.bitAdv) begin
      delayBit <= curBit;
    end
  end

  assign sdo = !strobe.idle && (strobe.delayMode ? delayBit : curBit);

endmodule

// File: rtl/tdm_tx_master.sv
module tdm_tx_master
  import tdm_tx_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int MAX_CH   = 8,
  parameter int DIV_W    = 6,
  parameter int PHASES   = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      txEn,
  input  logic [1:0]                cfgMode,
  input  logic [$clog2(MAX_CH)-1:0] cfgChCount,
  input  logic [2:0]                cfgChLen,
  input  logic [2:0]                cfgWordLen,
  input  logic                      cfgWsWide,
  input  logic                      cfgOvh,
  input  logic                      cfgPause,
  input  logic                      cfgSckPol,
  input  logic [DIV_W-1:0]          cfgDiv,
  input  logic [SAMPLE_W-1:0]       fifoData,
  input  logic                      fifoEmpty,
  output logic                      fifoPop,
  output logic                      underflow,
  output logic                      sck,
  output logic                      ws,
  output logic                      sdo
);

  txStrobe_t        strobe;
  logic [LEN_W-1:0] chLen;
  logic [LEN_W-1:0] wordLen;

  assign chLen   = decodeLen(cfgChLen);
  assign wordLen = decodeLen(cfgWordLen);

  tdm_tx_ctrl #(
    .MAX_CH(MAX_CH), .DIV_W(DIV_W), .PHASES(PHASES), .SAMPLE_W(SAMPLE_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .txEn(txEn), .fmt(txFormat_t'(cfgMode)),
    .chCount(cfgChCount), .chLen(chLen), .wordLen(wordLen),
    .wsWide(cfgWsWide), .sckPol(cfgSckPol), .divCode(cfgDiv),
    .strobe(strobe), .sck(sck), .ws(ws)
  );

  tdm_tx_datapath #(.SAMPLE_W(SAMPLE_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordLen(wordLen),
    .ovhBit(cfgOvh), .pause(cfgPause), .fifoData(fifoData),
    .fifoEmpty(fifoEmpty), .fifoPop(fifoPop), .underflow(underflow), .sdo(sdo)
  );

endmodule

// File: rtl/tdm_tx_checker.sv
module tdm_tx_checker (
  input logic clk,
  input logic rstN,
  input logic txEn,
  input logic cfgPause,
  input logic cfgSckPol,
  input logic fifoEmpty,
  input logic fifoPop,
  input logic underflow,
  input logic sck,
  input logic ws,
  input logic sdo
);

  // R1: with the enable low nothing is requested from the FIFO
  assert_idle_no_req_R1: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |-> (!fifoPop && !underflow));

  // R12: one edge after the enable is seen low, the line is idle
  assert_idle_lines_R12: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |=> (!ws && !sdo && (sck == cfgSckPol)));

  // R9: a pop only takes a present sample and lasts one cycle
  assert_pop_not_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> !fifoEmpty);

  assert_pop_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |=> !fifoPop);

  // R10: pause never touches the FIFO
  assert_pause_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgPause |-> (!fifoPop && !underflow));

  // R11: underflow is a single-cycle pulse
  assert_underflow_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> !underflow);

endmodule

bind tdm_tx_master tdm_tx_checker uChk (
  .clk(clk), .rstN(rstN), .txEn(txEn), .cfgPause(cfgPause),
  .cfgSckPol(cfgSckPol), .fifoEmpty(fifoEmpty), .fifoPop(fifoPop),
  .underflow(underflow), .sck(sck), .ws(ws), .sdo(sdo)
);

// File: tb/sim_tdm_tx_master.sv
module sim_tdm_tx_master;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_N      = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txEn = 1'b0;
  logic [1:0]  cfgMode = 2'd0;
  logic [2:0]  cfgChCount = 3'd1;
  logic [2:0]  cfgChLen = 3'd0;
  logic [2:0]  cfgWordLen = 3'd0;
  logic        cfgWsWide = 1'b1;
  logic        cfgOvh = 1'b0;
  logic        cfgPause = 1'b0;
  logic        cfgSckPol = 1'b0;
  logic [5:0]  cfgDiv = 6'd0;
  logic [31:0] fifoData;
  logic        fifoEmpty;
  logic        fifoPop, underflow, sck, ws, sdo;

  logic [31:0] mem [MEM_N];
  int rd = 0, avail = 0, popCnt = 0, ufCnt = 0;
  logic clrCnt = 1'b0;

  int nTests = 0, nFail = 0;
  bit done = 0;

  int gFmt, gChc, gCl, gWl, gOvh, gPause, gAvail, seed = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_tx_master u0 (
    .clk(clk), .rstN(rstN), .txEn(txEn), .cfgMode(cfgMode),
    .cfgChCount(cfgChCount), .cfgChLen(cfgChLen), .cfgWordLen(cfgWordLen),
    .cfgWsWide(cfgWsWide), .cfgOvh(cfgOvh), .cfgPause(cfgPause),
    .cfgSckPol(cfgSckPol), .cfgDiv(cfgDiv), .fifoData(fifoData),
    .fifoEmpty(fifoEmpty), .fifoPop(fifoPop), .underflow(underflow),
    .sck(sck), .ws(ws), .sdo(sdo)
  );

  assign fifoEmpty = (rd >= avail);
  assign fifoData  = (rd < MEM_N) ? mem[rd] : 32'd0;

  always @(posedge clk) begin
    if (clrCnt) begin
      rd <= 0; popCnt <= 0; ufCnt <= 0;
    end else begin
      if (fifoPop) begin rd <= rd + 1; popCnt <= popCnt + 1; end
      if (underflow) ufCnt <= ufCnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // R3: length code to bits
  function automatic int lenOf(input int code);
    case (code)
      0: return 8;  1: return 16; 2: return 18;
      3: return 20; 4: return 24; default: return 32;
    endcase
  endfunction

  // undelayed bit k of the stream (R4, R10, R11)
  function automatic logic expU(input int k);
    int f, fr, b, s, p, idx;
    f   = gCl * (gChc + 1);
    fr  = k / f; b = k % f; s = b / gCl; p = b % gCl;
    idx = fr * (gChc + 1) + s;
    if (p >= gWl) return gOvh[0];
    if (gPause != 0 || idx >= gAvail) return 1'b0;
    return mem[idx][gWl-1-p];
  endfunction

  function automatic logic expWs(input int k, input int wide);
    int f, b, s, p;
    f = gCl * (gChc + 1); b = k % f; s = b / gCl; p = b % gCl;
    case (gFmt)
      0: return s == 0;
      1: return s != 0;
      default: return (s == 0) && (wide != 0 || p == 0);
    endcase
  endfunction

  task automatic runCfg(input int fmt, input int chc, input int clc, input int wlc,
                        input int wide, input int ovh, input int pause, input int pol,
                        input int dv, input int frames, input int av, input string tag);
    int t, nBits, slots, expPop, expUf;
    logic e;
    @(negedge clk);
    txEn = 0;
    cfgMode = 2'(fmt); cfgChCount = 3'(chc); cfgChLen = 3'(clc); cfgWordLen = 3'(wlc);
    cfgWsWide = wide[0]; cfgOvh = ovh[0]; cfgPause = pause[0]; cfgSckPol = pol[0];
    cfgDiv = 6'(dv);
    gFmt = fmt; gChc = chc; gCl = lenOf(clc); gWl = lenOf(wlc);
    gOvh = ovh; gPause = pause; gAvail = av;
    for (int i = 0; i < MEM_N; i++) mem[i] = (32'h9E3779B9 * (i + seed)) ^ (32'(seed) << 11);
    seed++;
    avail = av; clrCnt = 1'b1;
    @(negedge clk);
    clrCnt = 1'b0;
    txEn = 1'b1;              // R12: slot 0 starts on the next edge
    @(posedge clk);
    t     = 8 * (dv + 1);
    nBits = frames * gCl * (chc + 1);
    for (int k = 0; k < nBits; k++) begin
      for (int j = 0; j < t; j++) begin
        @(negedge clk);
        if (j == 0 || j == t/2 - 1) chk(sck == pol[0], "R2 sck low half", sck, pol);
        if (j == t/2 || j == t - 1) chk(sck == !pol[0], "R2 sck high half", sck, !pol[0]);
        if (j == t/2) begin
          if (fmt == 1 || fmt == 3) e = (k == 0) ? 1'b0 : expU(k - 1);
          else e = expU(k);
          chk(sdo == e, {tag, " sdo"}, sdo, e);
          chk(ws == expWs(k, wide), {tag, " ws"}, ws, expWs(k, wide));
        end
        if (k == nBits - 1 && j == t - 1) txEn = 1'b0;
      end
    end
    @(negedge clk);
    @(negedge clk);
    slots  = frames * (chc + 1);
    expPop = (pause != 0) ? 0 : ((av < slots) ? av : slots);
    expUf  = (pause != 0) ? 0 : slots - expPop;
    chk(popCnt == expPop, {tag, " R9 pop count"}, popCnt, expPop);
    chk(ufCnt == expUf, {tag, " R11 underflow count"}, ufCnt, expUf);
    // R12 and R1: idle once the enable drops
    chk(ws == 1'b0 && sdo == 1'b0, "R12 idle data", {ws, sdo}, 0);
    chk(sck == pol[0], "R1 idle sck", sck, pol);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1;
      nTests++; nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sck == 1'b0 && ws == 1'b0 && sdo == 1'b0, "R1 reset lines", {sck, ws, sdo}, 0);
    chk(fifoPop == 1'b0 && underflow == 1'b0, "R1 reset requests", {fifoPop, underflow}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(sck == 1'b0 && ws == 1'b0 && sdo == 1'b0, "R1 idle after reset", {sck, ws, sdo}, 0);

    // R3, R4, R5, R6: every channel/word length pair in the two-slot framings
    for (int m = 0; m < 2; m++)
      for (int cl = 0; cl < 6; cl++)
        for (int wl = 0; wl <= cl; wl++)
          runCfg(m, 1, cl, wl, 1, (cl + wl) % 2, 0, 0, 0, 2, MEM_N,
                 (m == 0) ? "R5 LJ" : "R6 I2S");

    // R7, R8: TDM variants, both ws widths, 1/4/8 slots
    for (int m = 2; m < 4; m++)
      for (int w = 0; w < 2; w++)
        for (int c = 0; c < 3; c++)
          runCfg(m, (c == 0) ? 0 : ((c == 1) ? 3 : 7), 5, 4, w, w, 0, 0, 0, 1, MEM_N,
                 (m == 2) ? "R7 TDM A" : "R8 TDM B");

    // R2: divider code and inverted bit clock
    runCfg(0, 1, 1, 1, 1, 0, 0, 1, 2, 1, MEM_N, "R2 div+pol");
    runCfg(2, 1, 5, 3, 0, 1, 0, 0, 1, 1, MEM_N, "R2 div TDM");
    // R10: pause
    runCfg(1, 1, 4, 2, 1, 1, 1, 0, 0, 2, MEM_N, "R10 pause");
    // R11: FIFO runs dry part way
    runCfg(0, 1, 1, 1, 1, 0, 0, 0, 0, 3, 3, "R11 underflow");
    runCfg(3, 3, 5, 5, 1, 0, 0, 0, 0, 1, 0, "R11 empty TDM");

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule